// File: doc/BRIEF.md
# Shared Port Pin Controller with Serial-Input Takeover

This block controls a parallel port of general-purpose pins. Each pin has three stored bits: a direction bit, an output data bit and a pulldown-inhibit bit. A CPU reads and writes all three through a small register interface. The pad model for each pin is an output enable, an output value, a pulldown enable and a sampled input level.

One pin, chosen by a parameter, is shared with a synchronous serial peripheral. While the serial peripheral asserts its enable, this block turns that pin into a pure input with no pulldown and forwards its synchronized level to the serial data input. The CPU can still read and write the port registers during this time. As soon as the enable drops, the stored register values take control of the pin again, with no reinitialisation.

Every pad input passes through a synchronizer before it reaches the CPU read path or the serial data input.

Top module: `shared_pin_port`

## Requirements
- R1: After reset, the direction, data and pulldown-inhibit registers all read zero. Every pin has `pad_oe`=0 and `pad_pd_en`=1.
- R2: A write is made with `wr_en`=1 for one cycle and takes effect at the next rising clock edge. The `wr_sel` codes are: 0 selects data, 1 selects direction, 2 selects pulldown-inhibit, and 3 writes nothing. Registers that are not selected keep their values.
- R3: Output mode applies when a pin's direction bit is 1 and, for the shared pin, `ser_en` is 0. In this mode the pin has `pad_oe`=1 and `pad_pd_en`=0, and `pad_out` equals its data bit.
- R4: Input mode applies when a pin's direction bit is 0 and, for the shared pin, `ser_en` is 0. In this mode the pin has `pad_oe`=0, and `pad_pd_en` is the inverse of its pulldown-inhibit bit.
- R5: A change on `pad_in` reaches the read path and `ser_din` after exactly two rising clock edges. It is not visible after one edge.
- R6: A read with `rd_sel`=0 returns, for each bit, the data register where direction is 1 and the synchronized pin level where direction is 0. `rd_sel`=1 returns direction, `rd_sel`=2 returns pulldown-inhibit, and `rd_sel`=3 returns zero.
- R7: While `ser_en`=1, the shared pin has `pad_oe`=0 and `pad_pd_en`=0 whatever its stored bits are. The other pins are not affected.
- R8: While `ser_en`=1, CPU writes and reads of all registers work as usual. `ser_din` keeps following the synchronized level of the shared pin.
- R9: When `ser_en` falls, the stored direction, data and pulldown-inhibit bits control the shared pin in the same cycle.
- R10: No pin ever has `pad_oe` and `pad_pd_en` asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_sel | input | 2 | Register selected for the write |
| wr_data | input | PORT_W | Write data |
| rd_sel | input | 2 | Register selected for the read |
| rd_data | output | PORT_W | Read data (combinational) |
| ser_en | input | 1 | Serial peripheral owns the shared pin |
| ser_din | output | 1 | Synchronized shared-pin level sent to the serial peripheral |
| pad_in | input | PORT_W | Sampled pad levels |
| pad_oe | output | PORT_W | Pad output enables |
| pad_out | output | PORT_W | Pad output values |
| pad_pd_en | output | PORT_W | Pad pulldown enables |

## Verification
The bench aims at the takeover boundaries:
- While the serial peripheral holds the shared pin, it sets stored bits that would otherwise drive the pin or enable its pulldown, and checks that neither happens. A design that gated only the inhibit bit would leave the pulldown fighting the serial input.
- It drops the enable and checks the pad in that same cycle. A design that reset or delayed the stored bits would show a stale or idle pin.
- It compares the data read under mixed direction bits against a per-bit merge of register and pin, which catches a design that returns the register for input bits.
- It counts the synchronizer edges exactly, which exposes a missing or extra stage.

// File: rtl/spp_pkg.sv
package spp_pkg;
   typedef enum logic [1:0] {
      SEL_DATA  = 2'd0,
      SEL_DIR   = 2'd1,
      SEL_PDINH = 2'd2,
      SEL_NONE  = 2'd3
   } spp_sel_e;
endpackage

// File: rtl/spp_sync.sv
module spp_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("spp_sync: STAGES must be 2..4");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= '0;
         end else begin
            if (s == 0) begin
               stage_q[s] <= din;
            end else begin
               stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spp_regs.sv
module spp_regs
   import spp_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] data_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] pdinh_q
);
   logic hit_data, hit_dir, hit_pdinh;

   always_comb begin
      hit_data  = wr_en && (spp_sel_e'(wr_sel) == SEL_DATA);
      hit_dir   = wr_en && (spp_sel_e'(wr_sel) == SEL_DIR);
      hit_pdinh = wr_en && (spp_sel_e'(wr_sel) == SEL_PDINH);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         dir_q   <= '0;
         pdinh_q <= '0;
      end else begin
         if (hit_data)  data_q  <= wr_data;
         if (hit_dir)   dir_q   <= wr_data;
         if (hit_pdinh) pdinh_q <= wr_data;
      end
   end

   // R2
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1) |=> (dir_q == $past(wr_data)));

   // R2
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == 2'd0) |=> $stable(data_q));
endmodule

// File: rtl/spp_padctl.sv
module spp_padctl #(
   parameter int WIDTH      = 8,
   parameter int SERIAL_BIT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_en,
   input  logic [WIDTH-1:0] data_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] pdinh_q,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_pd_en
);
   if (SERIAL_BIT < 0 || SERIAL_BIT >= WIDTH) begin : g_bad_bit
      $error("spp_padctl: SERIAL_BIT out of range");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      if (i == SERIAL_BIT) begin : g_shared
         logic port_owns;
         assign port_owns    = !ser_en;
         assign pad_oe[i]    = port_owns && dir_q[i];
         assign pad_out[i]   = data_q[i];
         assign pad_pd_en[i] = port_owns && !dir_q[i] && !pdinh_q[i];
      end else begin : g_plain
         assign pad_oe[i]    = dir_q[i];
         assign pad_out[i]   = data_q[i];
         assign pad_pd_en[i] = !dir_q[i] && !pdinh_q[i];
      end
   end

   // R7
   ser_release_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_en |-> (!pad_oe[SERIAL_BIT] && !pad_pd_en[SERIAL_BIT]));

   // R10
   oe_pd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & pad_pd_en) == '0);
endmodule

// File: rtl/shared_pin_port.sv
module shared_pin_port
   import spp_pkg::*;
#(
   parameter int PORT_W      = 8,
   parameter int SERIAL_BIT  = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [PORT_W-1:0] wr_data,
   input  logic [1:0]        rd_sel,
   output logic [PORT_W-1:0] rd_data,
   input  logic              ser_en,
   output logic              ser_din,
   input  logic [PORT_W-1:0] pad_in,
   output logic [PORT_W-1:0] pad_oe,
   output logic [PORT_W-1:0] pad_out,
   output logic [PORT_W-1:0] pad_pd_en
);
   if (PORT_W < 1 || PORT_W > 32) begin : g_bad_width
      $error("shared_pin_port: PORT_W must be 1..32");
   end

   logic [PORT_W-1:0] data_q, dir_q, pdinh_q, pin_sync;

   spp_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_sync));

   spp_regs #(.WIDTH(PORT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .data_q(data_q), .dir_q(dir_q), .pdinh_q(pdinh_q));

   spp_padctl #(.WIDTH(PORT_W), .SERIAL_BIT(SERIAL_BIT)) u_pad (
      .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .data_q(data_q),
      .dir_q(dir_q), .pdinh_q(pdinh_q), .pad_oe(pad_oe),
      .pad_out(pad_out), .pad_pd_en(pad_pd_en));

   assign ser_din = pin_sync[SERIAL_BIT];

   always_comb begin
      unique case (spp_sel_e'(rd_sel))
         SEL_DATA:  rd_data = (dir_q & data_q) | (~dir_q & pin_sync);
         SEL_DIR:   rd_data = dir_q;
         SEL_PDINH: rd_data = pdinh_q;
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: tb/shared_pin_port_test.sv
module shared_pin_port_test;
   localparam int W  = 8;
   localparam int SB = 6;

   logic clk = 0, rst_n = 0, wr_en = 0, ser_en = 0;
   logic [1:0] wr_sel = 0, rd_sel = 0;
   logic [W-1:0] wr_data = 0, pad_in = 0;
   logic [W-1:0] rd_data, pad_oe, pad_out, pad_pd_en;
   logic ser_din;
   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   shared_pin_port #(.PORT_W(W), .SERIAL_BIT(SB)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .ser_en(ser_en), .ser_din(ser_din), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pd_en(pad_pd_en));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] s, logic [W-1:0] d);
      @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd(logic [1:0] s, output logic [W-1:0] v);
      rd_sel = s; #1 v = rd_data;
   endtask

   task automatic set_pin(logic [W-1:0] v);
      @(negedge clk); pad_in = v;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [W-1:0] v;
      rd(0, v); chk("R1 data", v, 0);
      rd(1, v); chk("R1 dir", v, 0);
      rd(2, v); chk("R1 pdinh", v, 0);
      chk("R1 oe", pad_oe, 0);
      chk("R1 pd", pad_pd_en, 8'hFF);
   endtask

   task automatic t_writes();
      logic [W-1:0] v;
      wr(2, 8'h5A); rd(2, v); chk("R2 pdinh write", v, 8'h5A);
      rd(1, v); chk("R2 dir untouched", v, 0);
      wr(3, 8'hFF);
      rd(2, v); chk("R2 sel3 pdinh kept", v, 8'h5A);
      rd(3, v); chk("R6 sel3 reads zero", v, 0);
      wr(2, 8'h00);
   endtask

   task automatic t_output_mode();
      wr(0, 8'hA5); wr(1, 8'hFF);
      chk("R3 oe", pad_oe, 8'hFF);
      chk("R3 out", pad_out, 8'hA5);
      chk("R3 pd off", pad_pd_en, 0);
   endtask

   task automatic t_input_pd();
      wr(1, 8'h00); wr(2, 8'h33);
      chk("R4 oe off", pad_oe, 0);
      chk("R4 pd", pad_pd_en, 8'hCC);
      wr(2, 8'h00);
   endtask

   task automatic t_sync();
      logic [W-1:0] v;
      @(negedge clk); pad_in = 8'h81;
      @(negedge clk); rd(0, v); chk("R5 one edge", v, 8'h00);
      chk("R5 ser_din one edge", ser_din, 0);
      @(negedge clk); rd(0, v); chk("R5 two edges", v, 8'h81);
      pad_in = 8'h40;
      repeat (2) @(negedge clk);
      chk("R5 ser_din", ser_din, 1);
   endtask

   task automatic t_read_view();
      logic [W-1:0] v;
      wr(0, 8'hA5); wr(1, 8'hF0); set_pin(8'h3C);
      rd(0, v); chk("R6 merged read", v, (8'hF0 & 8'hA5) | (~8'hF0 & 8'h3C));
   endtask

   task automatic t_serial();
      logic [W-1:0] v;
      wr(1, 8'h00); wr(2, 8'h00); wr(0, 8'h00);
      @(negedge clk); ser_en = 1; #1;
      chk("R7 pd off shared", pad_pd_en[SB], 0);
      chk("R7 others pd", pad_pd_en & ~(8'h1 << SB), 8'hFF & ~(8'h1 << SB));
      wr(1, 8'hFF); wr(0, 8'hFF);
      chk("R7 oe off shared", pad_oe[SB], 0);
      chk("R7 others oe", pad_oe, 8'hFF & ~(8'h1 << SB));
      rd(1, v); chk("R8 dir write during serial", v, 8'hFF);
      wr(1, 8'h00); set_pin(8'h40);
      chk("R8 ser_din follows pin", ser_din, 1);
      rd(0, v); chk("R8 read pin during serial", v, 8'h40);
      set_pin(8'h00);
      chk("R8 ser_din low", ser_din, 0);
      wr(1, 8'h40);
      @(negedge clk); ser_en = 0; #1;
      chk("R9 oe restored", pad_oe[SB], 1);
      chk("R9 out restored", pad_out[SB], 1);
      @(negedge clk); ser_en = 1; wr(1, 8'h00); wr(2, 8'h00);
      @(negedge clk); ser_en = 0; #1;
      chk("R9 pd restored", pad_pd_en[SB], 1);
      chk("R10 no overlap", pad_oe & pad_pd_en, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_writes();
      t_output_mode();
      t_input_pd();
      t_sync();
      t_read_view();
      t_serial();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule